// File: doc/BRIEF.md
# Counter-Driven Two-Player Score Game

This block pairs a parameterised multi-mode counter with a small scoring game. The counter steps up or down by one or by a programmable step, can be loaded with a starting value, and can be cleared. It reports its value and the direction of its last step. Whenever the counter sits at all ones, the "high" player scores a point. Whenever it sits at all zeros, the "low" player scores a point.

Each player has a tally. When either tally reaches the winning score, the game ends. `game_over_o` rises, `who_o` names the player that reached the score, and both tallies freeze until the next reset. The counter keeps running after the game ends. The counter width and the winning score are parameters.

Top module: `score_game`

## Requirements
- R1: While `rst_ni` is low at a rising clock edge, the next state has count, direction, both tallies, `game_over_o` and `who_o` all at zero. This reset is synchronous and takes priority over a load.
- R2: With mode 2'b00 and no load, the count rises by 1 on each clock edge, modulo 2^WIDTH.
- R3: With mode 2'b01 and no load, the count falls by 1 on each clock edge, modulo 2^WIDTH.
- R4: With mode 2'b10 the count rises by `step_i`, and with mode 2'b11 it falls by `step_i`. Both wrap modulo 2^WIDTH, and a step of zero holds the count.
- R5: When `init_i` is high at an edge, the count takes `init_val_i` at that edge, whatever the mode. Counting continues from that value at the following edge.
- R6: At every edge outside reset, `dir_down_o` takes `mode_i[0]`: 1 means a downward step and 0 means an upward step.
- R7: At an edge where the count is all ones, the high tally (`hi_tally_o`) rises by one. At an edge where the count is all zeros, the low tally (`lo_tally_o`) rises by one. This holds only while the game is not over.
- R8: Passing over the wrap point without landing on all ones or all zeros scores nothing.
- R9: `game_over_o` is high exactly when either tally equals WIN_SCORE. `who_o` is 1 when the high player reached it and 0 when the low player reached it.
- R10: Once the game is over, both tallies, `game_over_o` and `who_o` hold until reset, even while score events keep occurring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| init_i | input | 1 | Load request |
| init_val_i | input | WIDTH | Value to load |
| mode_i | input | 2 | Count mode (bit 1: use step, bit 0: down) |
| step_i | input | WIDTH | Step size for modes 2'b10 and 2'b11 |
| cnt_o | output | WIDTH | Current count |
| dir_down_o | output | 1 | Direction of the last step, 1 = down |
| hi_tally_o | output | TW | Points scored on all ones |
| lo_tally_o | output | TW | Points scored on all zeros |
| game_over_o | output | 1 | A tally has reached WIN_SCORE |
| who_o | output | 1 | Winner: 1 = high player, 0 = low player |

## Verification
The count and direction are registered, so they reflect the inputs sampled at the previous edge. A score event depends on the count already held, so its tally rises one edge after the count reaches all ones or all zeros. `game_over_o` and `who_o` are decoded from the tallies with no further register, so they change in the same cycle as the tally. The bench keeps a behavioural model that advances on each rising edge. It compares every output at the following falling edge, which lines each result up with the edge that produced it.

// File: rtl/score_game_pkg.sv
package score_game_pkg;
  typedef enum logic [1:0] {
    MODE_UP1  = 2'b00,
    MODE_DN1  = 2'b01,
    MODE_UPS  = 2'b10,
    MODE_DNS  = 2'b11
  } mode_e;

  typedef enum logic {
    PLAYER_LO = 1'b0,
    PLAYER_HI = 1'b1
  } player_e;
endpackage

// File: rtl/cnt_core.sv
module cnt_core #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic [WIDTH-1:0] init_val_i,
  input  logic [1:0]       mode_i,
  input  logic [WIDTH-1:0] step_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             dir_down_o,
  output logic             all_ones_o,
  output logic             all_zeros_o
);
  import score_game_pkg::*;

  logic [WIDTH-1:0] cnt_q, cnt_d, delta;
  logic             dir_q;
  mode_e            mode;

  assign mode  = mode_e'(mode_i);
  assign delta = (mode == MODE_UPS || mode == MODE_DNS) ? step_i : WIDTH'(1);

  always_comb begin
    if (init_i)         cnt_d = init_val_i;
    else if (mode_i[0]) cnt_d = cnt_q - delta;
    else                cnt_d = cnt_q + delta;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= mode_i[0];
    end
  end

  assign cnt_o       = cnt_q;
  assign dir_down_o  = dir_q;
  assign all_ones_o  = &cnt_q;
  assign all_zeros_o = ~|cnt_q;
endmodule

// File: rtl/score_tally.sv
module score_tally #(
  parameter int TW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hit_i,
  input  logic          freeze_i,
  output logic [TW-1:0] tally_o
);
  logic [TW-1:0] tally_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                tally_q <= '0;
    else if (hit_i && !freeze_i) tally_q <= tally_q + TW'(1);
  end

  assign tally_o = tally_q;
endmodule

// File: rtl/game_judge.sv
module game_judge #(
  parameter int TW        = 3,
  parameter int WIN_SCORE = 5
) (
  input  logic [TW-1:0] hi_tally_i,
  input  logic [TW-1:0] lo_tally_i,
  output logic          game_over_o,
  output logic          who_o
);
  import score_game_pkg::*;

  localparam logic [TW-1:0] LIMIT = TW'(WIN_SCORE);

  logic hi_done, lo_done;

  assign hi_done     = (hi_tally_i == LIMIT);
  assign lo_done     = (lo_tally_i == LIMIT);
  assign game_over_o = hi_done | lo_done;
  // high player wins a tie
  assign who_o       = hi_done ? PLAYER_HI : PLAYER_LO;
endmodule

// File: rtl/score_game.sv
module score_game #(
  parameter  int WIDTH     = 8,
  parameter  int WIN_SCORE = 5,
  localparam int TW        = $clog2(WIN_SCORE + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic [WIDTH-1:0] init_val_i,
  input  logic [1:0]       mode_i,
  input  logic [WIDTH-1:0] step_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             dir_down_o,
  output logic [TW-1:0]    hi_tally_o,
  output logic [TW-1:0]    lo_tally_o,
  output logic             game_over_o,
  output logic             who_o
);
  logic          ev_ones, ev_zeros, over;
  logic [1:0]    hit;
  logic [TW-1:0] tally [2];

  cnt_core #(.WIDTH(WIDTH)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_i      (init_i),
    .init_val_i  (init_val_i),
    .mode_i      (mode_i),
    .step_i      (step_i),
    .cnt_o       (cnt_o),
    .dir_down_o  (dir_down_o),
    .all_ones_o  (ev_ones),
    .all_zeros_o (ev_zeros)
  );

  // index 0 = low player, 1 = high player
  assign hit = {ev_ones, ev_zeros};

  for (genvar p = 0; p < 2; p++) begin : g_tally
    score_tally #(.TW(TW)) u_tally (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hit_i    (hit[p]),
      .freeze_i (over),
      .tally_o  (tally[p])
    );
  end

  game_judge #(.TW(TW), .WIN_SCORE(WIN_SCORE)) u_judge (
    .hi_tally_i  (tally[1]),
    .lo_tally_i  (tally[0]),
    .game_over_o (over),
    .who_o       (who_o)
  );

  assign hi_tally_o  = tally[1];
  assign lo_tally_o  = tally[0];
  assign game_over_o = over;
endmodule

// File: rtl/score_game_chk.sv
module score_game_chk #(
  parameter int WIDTH     = 8,
  parameter int WIN_SCORE = 5,
  parameter int TW        = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             init_i,
  input logic [WIDTH-1:0] init_val_i,
  input logic [1:0]       mode_i,
  input logic [WIDTH-1:0] step_i,
  input logic [WIDTH-1:0] cnt_o,
  input logic             dir_down_o,
  input logic [TW-1:0]    hi_tally_o,
  input logic [TW-1:0]    lo_tally_o,
  input logic             game_over_o,
  input logic             who_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (cnt_o == '0 && hi_tally_o == '0 && lo_tally_o == '0 && !game_over_o && !dir_down_o));

  // R5
  load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> cnt_o == $past(init_val_i));

  // R2
  up_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && mode_i == 2'b00) |=> cnt_o == WIDTH'($past(cnt_o) + WIDTH'(1)));

  // R3
  down_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && mode_i == 2'b01) |=> cnt_o == WIDTH'($past(cnt_o) - WIDTH'(1)));

  // R6
  dir_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> dir_down_o == $past(mode_i[0]));

  // R7
  hi_score_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '1 && !game_over_o) |=> hi_tally_o == TW'($past(hi_tally_o) + TW'(1)));

  // R9
  hi_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_tally_o == TW'(WIN_SCORE)) |-> (game_over_o && who_o));

  // R10
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    game_over_o |=> ($stable(hi_tally_o) && $stable(lo_tally_o) && game_over_o && $stable(who_o)));
endmodule

bind score_game score_game_chk #(.WIDTH(WIDTH), .WIN_SCORE(WIN_SCORE), .TW(TW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .init_i      (init_i),
  .init_val_i  (init_val_i),
  .mode_i      (mode_i),
  .step_i      (step_i),
  .cnt_o       (cnt_o),
  .dir_down_o  (dir_down_o),
  .hi_tally_o  (hi_tally_o),
  .lo_tally_o  (lo_tally_o),
  .game_over_o (game_over_o),
  .who_o       (who_o)
);

// File: tb/score_game_test.sv
module score_game_test;
  localparam int W   = 4;
  localparam int S   = 4;
  localparam int TW  = $clog2(S + 1);
  localparam int MOD = 1 << W;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          init_i = 1'b0;
  logic [W-1:0]  init_val_i = '0;
  logic [1:0]    mode_i = 2'b00;
  logic [W-1:0]  step_i = '0;
  logic [W-1:0]  cnt_o;
  logic          dir_down_o;
  logic [TW-1:0] hi_tally_o, lo_tally_o;
  logic          game_over_o, who_o;

  score_game #(.WIDTH(W), .WIN_SCORE(S)) uut (.*);

  always #5 clk_i = ~clk_i;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit done = 0;

  // behavioural reference
  int m_cnt = 0, m_dir = 0, m_hi = 0, m_lo = 0;

  always @(posedge clk_i) begin
    cycles++;
    if (!rst_ni) begin
      m_cnt = 0; m_dir = 0; m_hi = 0; m_lo = 0;
    end else begin
      int d;
      if (!(m_hi == S || m_lo == S)) begin
        if (m_cnt == MOD - 1) m_hi++;
        if (m_cnt == 0)       m_lo++;
      end
      d = mode_i[1] ? int'(step_i) : 1;
      if (init_i)         m_cnt = int'(init_val_i);
      else if (mode_i[0]) m_cnt = (m_cnt - d + MOD) % MOD;
      else                m_cnt = (m_cnt + d) % MOD;
      m_dir = mode_i[0];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (cycles > 0 && !done) begin
      int go, wh;
      go = (m_hi == S || m_lo == S);
      wh = (m_hi == S);
      chk(int'(cnt_o) == m_cnt, "R4 count", int'(cnt_o), m_cnt);
      chk(int'(dir_down_o) == m_dir, "R6 dir", int'(dir_down_o), m_dir);
      chk(int'(hi_tally_o) == m_hi, "R7 hi_tally", int'(hi_tally_o), m_hi);
      chk(int'(lo_tally_o) == m_lo, "R7 lo_tally", int'(lo_tally_o), m_lo);
      chk(int'(game_over_o) == go, "R9 game_over", int'(game_over_o), go);
      chk(int'(who_o) == (go ? wh : 0), "R9 who", int'(who_o), go ? wh : 0);
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; init_i = 1'b0;
    run(2);
    rst_ni = 1'b1;
  endtask

  initial begin
    run(3);
    // R1: reset state
    chk(cnt_o == '0 && hi_tally_o == '0 && lo_tally_o == '0 && !game_over_o, "R1 reset", int'(cnt_o), 0);
    // R1: reset beats load
    init_i = 1'b1; init_val_i = 4'd9; run(1);
    chk(cnt_o == '0, "R1 reset over load", int'(cnt_o), 0);
    init_i = 1'b0; rst_ni = 1'b1;

    // R2: up by one, through wrap and both events
    mode_i = 2'b00; run(3);
    chk(cnt_o == 4'd3, "R2 up1", int'(cnt_o), 3);
    run(14);

    // R3: down by one
    do_reset(); mode_i = 2'b01; run(3);
    chk(cnt_o == 4'd13 && dir_down_o, "R3 down1", int'(cnt_o), 13);
    run(10);

    // R4: up by step 3 (lands on 15), down by step 5
    do_reset(); mode_i = 2'b10; step_i = 4'd3; run(5);
    chk(cnt_o == 4'd15, "R4 step up", int'(cnt_o), 15);
    run(1);
    chk(hi_tally_o == 1 && cnt_o == 4'd2, "R7 hi on ones", int'(hi_tally_o), 1);
    mode_i = 2'b11; step_i = 4'd5; run(6);

    // R5: load mid-run, resume next edge
    do_reset(); mode_i = 2'b00; run(2);
    init_i = 1'b1; init_val_i = 4'd10; run(1);
    init_i = 1'b0;
    chk(cnt_o == 4'd10, "R5 load", int'(cnt_o), 10);
    run(1);
    chk(cnt_o == 4'd11, "R5 resume", int'(cnt_o), 11);

    // R8: stepping across wrap without landing on extremes
    do_reset(); mode_i = 2'b10; step_i = 4'd4;
    init_i = 1'b1; init_val_i = 4'd1; run(1); init_i = 1'b0;
    begin
      int lo0;
      lo0 = int'(lo_tally_o);
      run(12);
      chk(int'(lo_tally_o) == lo0 && hi_tally_o == '0, "R8 wrap unscored", int'(lo_tally_o), lo0);
    end

    // R9/R10: low player wins by holding zero
    do_reset(); mode_i = 2'b10; step_i = 4'd0; run(S + 1);
    chk(game_over_o && !who_o && lo_tally_o == TW'(S), "R9 low wins", int'(lo_tally_o), S);
    run(5);
    chk(lo_tally_o == TW'(S) && game_over_o, "R10 frozen", int'(lo_tally_o), S);

    // R9/R10: high player wins by holding all ones
    do_reset(); init_i = 1'b1; init_val_i = 4'hF; run(1); init_i = 1'b0;
    run(S + 1);
    chk(game_over_o && who_o, "R9 high wins", int'(who_o), 1);
    run(4);
    chk(hi_tally_o == TW'(S), "R10 hi frozen", int'(hi_tally_o), S);

    // R6: direction follows mode bit 0
    mode_i = 2'b11; step_i = 4'd2; run(1);
    chk(dir_down_o == 1'b1, "R6 dir down", int'(dir_down_o), 1);
    mode_i = 2'b00; run(1);
    chk(dir_down_o == 1'b0, "R6 dir up", int'(dir_down_o), 0);

    // R1: reset mid-game clears the game
    rst_ni = 1'b0; run(1);
    chk(!game_over_o && hi_tally_o == '0, "R1 clear game", int'(game_over_o), 0);
    rst_ni = 1'b1; run(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  always @(posedge clk_i) begin
    if (cycles > 20000 && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule